// File: doc/BRIEF.md
# DSP Single-Transfer Load/Store Unit

This block moves one operand per cycle between a 32-bit data bus and a small DSP register file. The file holds six 32-bit operand registers (X0, X1, Y0, Y1, M0, M1) and two 40-bit accumulators, A0 and A1. The top 8 bits of each accumulator form a guard byte, and that byte can also be reached on its own as A0G or A1G. A transfer names a word or a longword, a load or a store, a register, one of four address pointers and a post-update mode. The block drives the bus address from the chosen pointer and formats the data in both directions. In the same cycle it writes the updated pointer back.

Instruction fetch uses the same bus. When both ask for the bus in one cycle, the data transfer wins and the fetch is held with a stall for that cycle. The pointer file is loaded through a dedicated write port. The +index update mode takes its offset from an index input.

Top module: `dsp_xfer_unit`

## Requirements
- R1: Register select codes are X0=0, X1=1, Y0=2, Y1=3, M0=4, M1=5, A0=6, A1=7, A0G=8, A1G=9. A word load (long_i=0, store_i=0) into codes 0 to 7 writes bus_rdata_i[15:0] into bits 31:16 of the register and clears bits 15:0.
- R2: A longword load (long_i=1) writes all 32 bits of bus_rdata_i into codes 0 to 7. A longword store drives all 32 register bits on bus_wdata_o.
- R3: Any load into A0 or A1, word or longword, sets that accumulator's guard byte to 8 copies of the new bit 31.
- R4: A word store from codes 0 to 7 drives register bits 31:16 on bus_wdata_o[15:0] and zeros on bus_wdata_o[31:16].
- R5: A load into A0G or A1G writes only bus_rdata_i[7:0] into the guard byte. The 32-bit body of the accumulator is unchanged.
- R6: A store from A0G or A1G drives the guard byte on bus_wdata_o[7:0]. The bits above carry its sign extension and users must treat them as undefined.
- R7: During a transfer, bus_addr_o is the selected pointer's value before the update. From the next cycle the pointer holds its post-updated value. upd_i encodes 0 = keep, 1 = +step, 2 = -step, 3 = +idx_i, where step is 2 for a word and 4 for a longword.
- R8: When req_i and fetch_req_i are both high, the bus carries the transfer (bus_xfer_o=1) and fetch_stall_o is 1 for that cycle. Without req_i, bus_xfer_o, bus_we_o and fetch_stall_o are 0 and bus_addr_o equals fetch_addr_i. bus_we_o is 1 only for store transfers.
- R9: After reset all registers, guard bytes and pointers read as zero.
- R10: ptr_ld_i writes ptr_ld_data_i into pointer ptr_ld_sel_i. The next transfer through that pointer uses that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Data transfer request, one transfer per cycle |
| store_i | input | 1 | 1 = store, 0 = load |
| long_i | input | 1 | 1 = longword, 0 = word |
| reg_sel_i | input | 4 | Register select code |
| ptr_sel_i | input | PSEL_W | Pointer used for the address |
| upd_i | input | 2 | Pointer post-update mode |
| idx_i | input | ADDR_W | Offset for the +index update |
| ptr_ld_i | input | 1 | Pointer write enable |
| ptr_ld_sel_i | input | PSEL_W | Pointer to write |
| ptr_ld_data_i | input | ADDR_W | Pointer write value |
| fetch_req_i | input | 1 | Instruction fetch request |
| fetch_addr_i | input | ADDR_W | Instruction fetch address |
| fetch_stall_o | output | 1 | Fetch held off this cycle |
| bus_addr_o | output | ADDR_W | Shared bus address |
| bus_xfer_o | output | 1 | Bus owned by a data transfer |
| bus_we_o | output | 1 | Bus write strobe |
| bus_long_o | output | 1 | Bus access is a longword |
| bus_wdata_o | output | 32 | Store data |
| bus_rdata_i | input | 32 | Load data, valid in the transfer cycle |

## Verification
Word loads use data whose two halves differ, so a unit that stores the wrong half or leaves the low half set produces a different value on a later longword store. Accumulator loads use data with bit 31 both set and clear, followed by guard stores, so guard sign extension shows up at the ports. A byte load into a guard byte is followed by a store of the accumulator body, which shows whether the body was disturbed. One pointer walks through every update mode at both sizes, including a negative index. A mixed run of transfers with fetch contention, checked cycle by cycle against the bench model, separates arbitration errors from formatting errors.

// File: rtl/dsp_xfer_pkg.sv
package dsp_xfer_pkg;
  localparam int DATA_W = 32;
  localparam int HALF_W = DATA_W / 2;
  localparam int NREG   = 8;
  localparam int NACC   = 2;

  localparam logic [3:0] SEL_A0  = 4'd6;
  localparam logic [3:0] SEL_A1  = 4'd7;
  localparam logic [3:0] SEL_A0G = 4'd8;
  localparam logic [3:0] SEL_A1G = 4'd9;

  typedef enum logic [1:0] {
    UPD_KEEP = 2'd0,
    UPD_INC  = 2'd1,
    UPD_DEC  = 2'd2,
    UPD_IDX  = 2'd3
  } upd_e;
endpackage

// File: rtl/dsp_regfile.sv
module dsp_regfile
  import dsp_xfer_pkg::*;
#(
  parameter int GUARD_W = 8
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_en_i,
  input  logic                               long_i,
  input  logic [3:0]                         sel_i,
  input  logic [DATA_W-1:0]                  rdata_i,
  output logic [NREG-1:0][DATA_W-1:0]        regs_o,
  output logic [NACC-1:0][GUARD_W-1:0]       guard_o
);
  logic [DATA_W-1:0] wr_val;

  // word data lands in the upper half, lower half cleared
  assign wr_val = long_i ? rdata_i : {rdata_i[HALF_W-1:0], {HALF_W{1'b0}}};

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) regs_o[i] <= '0;
      else if (wr_en_i && sel_i == 4'(i)) regs_o[i] <= wr_val;
    end
  end

  for (genvar g = 0; g < NACC; g++) begin : g_guard
    localparam logic [3:0] BODY_SEL  = SEL_A0 + 4'(g);
    localparam logic [3:0] GUARD_SEL = SEL_A0G + 4'(g);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) guard_o[g] <= '0;
      else if (wr_en_i && sel_i == BODY_SEL) guard_o[g] <= {GUARD_W{wr_val[DATA_W-1]}};
      else if (wr_en_i && sel_i == GUARD_SEL) guard_o[g] <= rdata_i[GUARD_W-1:0];
    end
  end
endmodule

// File: rtl/dsp_store_fmt.sv
module dsp_store_fmt
  import dsp_xfer_pkg::*;
#(
  parameter int GUARD_W = 8
) (
  input  logic                         long_i,
  input  logic [3:0]                   sel_i,
  input  logic [NREG-1:0][DATA_W-1:0]  regs_i,
  input  logic [NACC-1:0][GUARD_W-1:0] guard_i,
  output logic [DATA_W-1:0]            wdata_o
);
  logic [DATA_W-1:0]  src;
  logic [GUARD_W-1:0] gsrc;

  assign src  = regs_i[sel_i[2:0]];
  assign gsrc = guard_i[sel_i[0]];

  always_comb begin
    if (sel_i < 4'(NREG)) begin
      wdata_o = long_i ? src : {{HALF_W{1'b0}}, src[DATA_W-1:HALF_W]};
    end else if (sel_i == SEL_A0G || sel_i == SEL_A1G) begin
      wdata_o = {{(DATA_W-GUARD_W){gsrc[GUARD_W-1]}}, gsrc};
    end else begin
      wdata_o = '0;
    end
  end
endmodule

// File: rtl/dsp_ptr_unit.sv
module dsp_ptr_unit
  import dsp_xfer_pkg::*;
#(
  parameter int NUM_PTR = 4,
  parameter int ADDR_W  = 32,
  parameter int PSEL_W  = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            upd_en_i,
  input  logic                            long_i,
  input  logic [PSEL_W-1:0]               sel_i,
  input  logic [1:0]                      mode_i,
  input  logic [ADDR_W-1:0]               idx_i,
  input  logic                            ld_en_i,
  input  logic [PSEL_W-1:0]               ld_sel_i,
  input  logic [ADDR_W-1:0]               ld_data_i,
  output logic [ADDR_W-1:0]               cur_o,
  output logic [NUM_PTR-1:0][ADDR_W-1:0]  ptrs_o
);
  localparam logic [ADDR_W-1:0] STEP_WORD = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] STEP_LONG = ADDR_W'(4);

  logic [ADDR_W-1:0] step, nxt;

  assign cur_o = ptrs_o[sel_i];
  assign step  = long_i ? STEP_LONG : STEP_WORD;

  always_comb begin
    unique case (upd_e'(mode_i))
      UPD_INC:  nxt = cur_o + step;
      UPD_DEC:  nxt = cur_o - step;
      UPD_IDX:  nxt = cur_o + idx_i;
      default:  nxt = cur_o;
    endcase
  end

  for (genvar i = 0; i < NUM_PTR; i++) begin : g_ptr
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ptrs_o[i] <= '0;
      else if (upd_en_i && sel_i == PSEL_W'(i)) ptrs_o[i] <= nxt;
      else if (ld_en_i && ld_sel_i == PSEL_W'(i)) ptrs_o[i] <= ld_data_i;
    end
  end
endmodule

// File: rtl/dsp_bus_arb.sv
module dsp_bus_arb
  import dsp_xfer_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              xfer_req_i,
  input  logic              xfer_we_i,
  input  logic              xfer_long_i,
  input  logic [ADDR_W-1:0] xfer_addr_i,
  input  logic [DATA_W-1:0] xfer_wdata_i,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              fetch_stall_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_xfer_o,
  output logic              bus_we_o,
  output logic              bus_long_o,
  output logic [DATA_W-1:0] bus_wdata_o
);
  // data transfer has fixed priority over fetch
  assign bus_xfer_o    = xfer_req_i;
  assign fetch_stall_o = xfer_req_i & fetch_req_i;
  assign bus_addr_o    = xfer_req_i ? xfer_addr_i : fetch_addr_i;
  assign bus_we_o      = xfer_req_i & xfer_we_i;
  assign bus_long_o    = xfer_req_i & xfer_long_i;
  assign bus_wdata_o   = (xfer_req_i & xfer_we_i) ? xfer_wdata_i : '0;
endmodule

// File: rtl/dsp_xfer_unit.sv
module dsp_xfer_unit
  import dsp_xfer_pkg::*;
#(
  parameter int NUM_PTR = 4,
  parameter int ADDR_W  = 32,
  parameter int GUARD_W = 8,
  parameter int PSEL_W  = (NUM_PTR > 1) ? $clog2(NUM_PTR) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              store_i,
  input  logic              long_i,
  input  logic [3:0]        reg_sel_i,
  input  logic [PSEL_W-1:0] ptr_sel_i,
  input  logic [1:0]        upd_i,
  input  logic [ADDR_W-1:0] idx_i,
  input  logic              ptr_ld_i,
  input  logic [PSEL_W-1:0] ptr_ld_sel_i,
  input  logic [ADDR_W-1:0] ptr_ld_data_i,
  input  logic              fetch_req_i,
  input  logic [ADDR_W-1:0] fetch_addr_i,
  output logic              fetch_stall_o,
  output logic [ADDR_W-1:0] bus_addr_o,
  output logic              bus_xfer_o,
  output logic              bus_we_o,
  output logic              bus_long_o,
  output logic [DATA_W-1:0] bus_wdata_o,
  input  logic [DATA_W-1:0] bus_rdata_i
);
  logic [NREG-1:0][DATA_W-1:0]   regs_q;
  logic [NACC-1:0][GUARD_W-1:0]  guard_q;
  logic [NUM_PTR-1:0][ADDR_W-1:0] ptrs_q;
  logic [ADDR_W-1:0]             cur_addr;
  logic [DATA_W-1:0]             st_data;
  logic                          load_en;

  assign load_en = req_i & ~store_i & (reg_sel_i <= SEL_A1G);

  dsp_regfile #(.GUARD_W(GUARD_W)) u_rf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (load_en),
    .long_i  (long_i),
    .sel_i   (reg_sel_i),
    .rdata_i (bus_rdata_i),
    .regs_o  (regs_q),
    .guard_o (guard_q)
  );

  dsp_store_fmt #(.GUARD_W(GUARD_W)) u_fmt (
    .long_i  (long_i),
    .sel_i   (reg_sel_i),
    .regs_i  (regs_q),
    .guard_i (guard_q),
    .wdata_o (st_data)
  );

  dsp_ptr_unit #(.NUM_PTR(NUM_PTR), .ADDR_W(ADDR_W), .PSEL_W(PSEL_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_en_i  (req_i),
    .long_i    (long_i),
    .sel_i     (ptr_sel_i),
    .mode_i    (upd_i),
    .idx_i     (idx_i),
    .ld_en_i   (ptr_ld_i),
    .ld_sel_i  (ptr_ld_sel_i),
    .ld_data_i (ptr_ld_data_i),
    .cur_o     (cur_addr),
    .ptrs_o    (ptrs_q)
  );

  dsp_bus_arb #(.ADDR_W(ADDR_W)) u_arb (
    .xfer_req_i    (req_i),
    .xfer_we_i     (store_i),
    .xfer_long_i   (long_i),
    .xfer_addr_i   (cur_addr),
    .xfer_wdata_i  (st_data),
    .fetch_req_i   (fetch_req_i),
    .fetch_addr_i  (fetch_addr_i),
    .fetch_stall_o (fetch_stall_o),
    .bus_addr_o    (bus_addr_o),
    .bus_xfer_o    (bus_xfer_o),
    .bus_we_o      (bus_we_o),
    .bus_long_o    (bus_long_o),
    .bus_wdata_o   (bus_wdata_o)
  );
endmodule

// File: rtl/dsp_xfer_chk.sv
module dsp_xfer_chk
  import dsp_xfer_pkg::*;
#(
  parameter int GUARD_W = 8
) (
  input logic                         clk_i,
  input logic                         rst_ni,
  input logic                         req_i,
  input logic                         store_i,
  input logic                         long_i,
  input logic [3:0]                   reg_sel_i,
  input logic                         fetch_req_i,
  input logic                         fetch_stall_o,
  input logic                         bus_xfer_o,
  input logic                         bus_we_o,
  input logic [DATA_W-1:0]            bus_wdata_o,
  input logic [NREG-1:0][DATA_W-1:0]  regs_q,
  input logic [NACC-1:0][GUARD_W-1:0] guard_q
);
  // R8
  stall_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_stall_o |-> (bus_xfer_o && fetch_req_i));

  // R8
  write_owner_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_we_o |-> (bus_xfer_o && store_i));

  // R1
  word_load_low_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !store_i && !long_i && reg_sel_i < 4'd8)
      |=> regs_q[$past(reg_sel_i[2:0])][HALF_W-1:0] == '0);

  // R3
  a0_guard_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !store_i && reg_sel_i == SEL_A0)
      |=> guard_q[0] == {GUARD_W{regs_q[6][DATA_W-1]}});

  // R3
  a1_guard_sign_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !store_i && reg_sel_i == SEL_A1)
      |=> guard_q[1] == {GUARD_W{regs_q[7][DATA_W-1]}});

  // R4
  word_store_upper_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && store_i && !long_i && reg_sel_i < 4'd8) |-> bus_wdata_o[DATA_W-1:HALF_W] == '0);

  // R5
  guard_load_body_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && !store_i && reg_sel_i == SEL_A0G) |=> $stable(regs_q[6]));
endmodule

bind dsp_xfer_unit dsp_xfer_chk #(.GUARD_W(GUARD_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .req_i         (req_i),
  .store_i       (store_i),
  .long_i        (long_i),
  .reg_sel_i     (reg_sel_i),
  .fetch_req_i   (fetch_req_i),
  .fetch_stall_o (fetch_stall_o),
  .bus_xfer_o    (bus_xfer_o),
  .bus_we_o      (bus_we_o),
  .bus_wdata_o   (bus_wdata_o),
  .regs_q        (regs_q),
  .guard_q       (guard_q)
);

// File: tb/dsp_xfer_unit_bench.sv
module dsp_xfer_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 0, rst_ni = 0;
  logic        req_i = 0, store_i = 0, long_i = 0;
  logic [3:0]  reg_sel_i = 0;
  logic [1:0]  ptr_sel_i = 0, upd_i = 0, ptr_ld_sel_i = 0;
  logic [31:0] idx_i = 0, ptr_ld_data_i = 0, fetch_addr_i = 0, bus_rdata_i = 0;
  logic        ptr_ld_i = 0, fetch_req_i = 0;
  logic        fetch_stall_o, bus_xfer_o, bus_we_o, bus_long_o;
  logic [31:0] bus_addr_o, bus_wdata_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  logic [31:0] m_reg [8];
  logic [7:0]  m_g   [2];
  logic [31:0] m_ptr [4];

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  dsp_xfer_unit u_dsp_xfer_unit (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_wdata();
    if (reg_sel_i < 8) return long_i ? m_reg[reg_sel_i[2:0]] : {16'h0, m_reg[reg_sel_i[2:0]][31:16]};
    if (reg_sel_i == 8 || reg_sel_i == 9) return {24'h0, m_g[reg_sel_i[0]]};
    return 32'h0;
  endfunction

  // compare at mid-cycle, then advance model at the edge
  task automatic step(string tag);
    logic [31:0] wv, stp, w;
    #1;
    if (req_i) begin
      chk(tag, bus_addr_o, m_ptr[ptr_sel_i]);
      chk("R8", {31'h0, bus_xfer_o}, 32'h1);
      chk("R8", {31'h0, bus_we_o}, {31'h0, store_i});
      chk("R8", {31'h0, fetch_stall_o}, {31'h0, fetch_req_i});
      if (store_i) begin
        w = bus_wdata_o;
        if (reg_sel_i == 8 || reg_sel_i == 9) w = {24'h0, w[7:0]};
        chk(tag, w, exp_wdata());
      end
    end else begin
      chk("R8", {30'h0, bus_xfer_o, fetch_stall_o}, 32'h0);
      chk("R8", {31'h0, bus_we_o}, 32'h0);
      if (fetch_req_i) chk("R8", bus_addr_o, fetch_addr_i);
    end
    @(posedge clk_i);
    if (req_i) begin
      if (!store_i) begin
        wv = long_i ? bus_rdata_i : {bus_rdata_i[15:0], 16'h0};
        if (reg_sel_i < 8) m_reg[reg_sel_i[2:0]] = wv;
        if (reg_sel_i == 6 || reg_sel_i == 7) m_g[reg_sel_i[0]] = {8{wv[31]}};
        if (reg_sel_i == 8 || reg_sel_i == 9) m_g[reg_sel_i[0]] = bus_rdata_i[7:0];
      end
      stp = long_i ? 4 : 2;
      case (upd_i)
        2'd1: m_ptr[ptr_sel_i] = m_ptr[ptr_sel_i] + stp;
        2'd2: m_ptr[ptr_sel_i] = m_ptr[ptr_sel_i] - stp;
        2'd3: m_ptr[ptr_sel_i] = m_ptr[ptr_sel_i] + idx_i;
        default: ;
      endcase
    end else if (ptr_ld_i) begin
      m_ptr[ptr_ld_sel_i] = ptr_ld_data_i;
    end
    @(negedge clk_i);
    req_i = 0; ptr_ld_i = 0;
  endtask

  task automatic xfer(string tag, bit st, bit lg, logic [3:0] sel, logic [1:0] p,
                      logic [1:0] up, logic [31:0] data, bit fr);
    req_i = 1; store_i = st; long_i = lg; reg_sel_i = sel; ptr_sel_i = p;
    upd_i = up; bus_rdata_i = data; fetch_req_i = fr; fetch_addr_i = 32'h0000_0400;
    step(tag);
  endtask

  task automatic idle(bit fr, logic [31:0] fa);
    fetch_req_i = fr; fetch_addr_i = fa;
    step("R8");
  endtask

  task automatic ptr_load(logic [1:0] s, logic [31:0] v);
    ptr_ld_i = 1; ptr_ld_sel_i = s; ptr_ld_data_i = v; fetch_req_i = 0;
    step("R10");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    if (!done) begin
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [31:0] lf;
    for (int i = 0; i < 8; i++) m_reg[i] = 0;
    for (int i = 0; i < 2; i++) m_g[i] = 0;
    for (int i = 0; i < 4; i++) m_ptr[i] = 0;
    repeat (2) @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);

    // R9 reset state
    xfer("R9", 1, 1, 4'd0, 2'd0, 2'd0, 0, 1);
    xfer("R9", 1, 1, 4'd7, 2'd3, 2'd0, 0, 0);
    xfer("R9", 1, 0, 4'd9, 2'd1, 2'd0, 0, 0);
    idle(1, 32'h0000_0100);
    idle(0, 32'h0);

    // R10 pointer loads
    ptr_load(2'd0, 32'h0000_1000);
    ptr_load(2'd1, 32'h0000_2000);
    ptr_load(2'd2, 32'h0000_3000);
    ptr_load(2'd3, 32'h0000_4000);
    xfer("R10", 1, 1, 4'd0, 2'd2, 2'd0, 0, 0);
    xfer("R10", 1, 1, 4'd0, 2'd3, 2'd0, 0, 1);

    // R1 word load into X1, then R4 word store
    xfer("R1", 0, 0, 4'd1, 2'd0, 2'd0, 32'hABCD_1234, 1);
    xfer("R1", 1, 1, 4'd1, 2'd0, 2'd0, 0, 0);
    xfer("R4", 1, 0, 4'd1, 2'd0, 2'd0, 0, 1);

    // R2 longword
    xfer("R2", 0, 1, 4'd2, 2'd0, 2'd0, 32'hDEAD_BEEF, 0);
    xfer("R2", 1, 1, 4'd2, 2'd0, 2'd0, 0, 1);
    xfer("R4", 1, 0, 4'd2, 2'd0, 2'd0, 0, 0);

    // R3 guard sign extension
    xfer("R3", 0, 1, 4'd6, 2'd0, 2'd0, 32'h8000_0001, 0);
    xfer("R3", 1, 0, 4'd8, 2'd0, 2'd0, 0, 0);
    xfer("R3", 0, 0, 4'd7, 2'd0, 2'd0, 32'h5555_7FFF, 0);
    xfer("R3", 1, 0, 4'd9, 2'd0, 2'd0, 0, 0);
    xfer("R3", 0, 0, 4'd7, 2'd0, 2'd0, 32'h0000_8000, 1);
    xfer("R3", 1, 1, 4'd9, 2'd0, 2'd0, 0, 0);

    // R5 guard byte load leaves body, R6 guard store
    xfer("R5", 0, 0, 4'd8, 2'd0, 2'd0, 32'hFFFF_12C5, 0);
    xfer("R5", 1, 1, 4'd6, 2'd0, 2'd0, 0, 0);
    xfer("R6", 1, 0, 4'd8, 2'd0, 2'd0, 0, 1);
    xfer("R6", 1, 1, 4'd8, 2'd0, 2'd0, 0, 0);

    // R7 pointer post-update, each mode at both sizes
    xfer("R7", 1, 0, 4'd4, 2'd1, 2'd1, 0, 1);
    xfer("R7", 1, 1, 4'd4, 2'd1, 2'd1, 0, 0);
    xfer("R7", 0, 1, 4'd5, 2'd1, 2'd2, 32'h1111_2222, 1);
    xfer("R7", 0, 0, 4'd5, 2'd1, 2'd2, 32'h3333_4444, 0);
    idx_i = 32'h0000_0020;
    xfer("R7", 1, 0, 4'd5, 2'd1, 2'd3, 0, 0);
    idx_i = 32'hFFFF_FFF0;
    xfer("R7", 1, 1, 4'd5, 2'd1, 2'd3, 0, 0);
    xfer("R7", 1, 1, 4'd5, 2'd1, 2'd0, 0, 1);
    xfer("R7", 1, 1, 4'd5, 2'd1, 2'd0, 0, 0);

    // R8 arbitration around transfers
    idle(1, 32'h0000_0ABC);
    xfer("R8", 0, 1, 4'd3, 2'd2, 2'd1, 32'h0F0F_F0F0, 1);
    idle(1, 32'h0000_0ABE);

    // mixed run, checked against model every cycle
    lf = 32'h1357_9BDF;
    for (int i = 0; i < 60; i++) begin
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
      idx_i = {24'h0, lf[15:8]};
      if (lf[4:3] == 2'b00) idle(lf[5], lf);
      else xfer("R2", lf[6], lf[7], 4'(lf[19:16] % 10), lf[21:20], lf[23:22], lf ^ 32'hA5A5_5A5A, lf[24]);
    end
    for (int s = 0; s < 10; s++) xfer("R2", 1, 1, 4'(s), 2'd0, 2'd0, 0, 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule